// File: doc/BRIEF.md
# Section alarm serial port

This block turns a parallel snapshot of receive section status into a fixed 72-bit serial frame. It shifts the frame out one bit per cycle of a slow port clock, nominally 576 kHz, which gives a new frame every 8 kHz period. The snapshot holds five things:

- the generated remote defect indication (RDI);
- four section alarm flags;
- two 16-bit detected error counts;
- the filtered K1 and K2 protection bytes;
- the filtered S1 synchronisation status byte.

A single-cycle load strobe captures the snapshot. The captured snapshot enters the stream only at the next frame boundary, so a frame never mixes data from two snapshots. When no new strobe arrives, the most recent snapshot is sent again in every frame.

A marker output goes high for one port-clock cycle in each frame. That cycle is the slot that carries the RDI bit, which is the first slot of the frame. A receiver aligns to the frame on this marker. Until the first snapshot has been loaded, the data line stays low and the marker never fires. The clocking, defect detection and byte filtering all happen upstream of this block.

Top module: `sec_alarm_tx`

## Requirements
- R1: During and after synchronous reset, `ser_data` and `ser_mark` are 0. They stay 0 in every cycle before the first frame boundary that follows the first `snap_load`.
- R2: Once running, `ser_mark` is high for exactly one cycle in every 72 port-clock cycles and is low in the other 71 slots.
- R3: The cycle in which `ser_mark` is high carries the RDI bit on `ser_data` (slot 0 of the frame).
- R4: Slots 1 to 60 carry the fields in this order, each most significant bit first:
  - the alarm flags `in_alarm[3:0]`, with bit 3 = loss of signal, bit 2 = loss of frame, bit 1 = severely errored frame, bit 0 = line AIS;
  - `in_b1_err[15:0]`;
  - `in_b2_err[15:0]`;
  - `in_k1[7:0]`;
  - `in_k2[7:0]`;
  - `in_s1[7:0]`.
- R5: Slots 61 to 71 are always 0.
- R6: A `snap_load` sampled at any clock edge of frame N, including the edges that output slot 0 and slot 71, leaves the rest of frame N unchanged. The new snapshot is sent from frame N+1 on.
- R7: With no further `snap_load`, every following frame repeats the last loaded snapshot.
- R8: When several `snap_load` pulses fall within one frame, the next frame carries the snapshot from the last of them.
- R9: A first `snap_load` sampled in frame N makes the first marker appear in the slot 0 of frame N+1. Frames count from the first clock edge after reset, with 72 edges per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| snap_load | input | 1 | Single-cycle strobe that captures the status snapshot |
| in_rdi | input | 1 | Generated remote defect indication |
| in_alarm | input | 4 | Section alarm flags (LOS, LOF, SEF, line AIS from bit 3 down) |
| in_b1_err | input | 16 | Section parity error count |
| in_b2_err | input | 16 | Line parity error count |
| in_k1 | input | 8 | Filtered K1 byte |
| in_k2 | input | 8 | Filtered K2 byte |
| in_s1 | input | 8 | Filtered S1 synchronisation status byte |
| ser_data | output | 1 | Serial status bit, registered |
| ser_mark | output | 1 | Marker, high in the RDI slot, registered |

## Verification
The checker assumes only two things. Reset is synchronous. `snap_load` is sampled on the port clock, and the status fields are valid whenever it is high. It needs nothing about how strobes are spaced. From the first marker on, it measures the spacing between markers with its own counter, and it checks that the padding slots are zero against that same counter. The stimulus drives the strobe and the fields at the falling edge and holds the strobe for exactly one cycle. It places strobes at chosen slots (1, 10, 30, 50, 71 and slot 0) counted from the bench's own edge count since reset. That keeps every load inside the interface the checker assumes, and it still reaches the boundary slots named in R6.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int unsigned SAP_FRAME_LEN = 72;
  localparam int unsigned SAP_ALM_W     = 4;
  localparam int unsigned SAP_ERR_W     = 16;
  localparam int unsigned SAP_BYTE_W    = 8;

  typedef enum logic {
    SRC_EMPTY = 1'b0,
    SRC_HELD  = 1'b1
  } src_state_t;

endpackage

// File: rtl/sap_slot_ctr.sv
module sap_slot_ctr #(
  parameter int unsigned FRAME_LEN = 72
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic [$clog2(FRAME_LEN)-1:0] slot,
  output logic                         frame_first,
  output logic                         frame_last
);

  localparam int unsigned CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST_SLOT = CW'(FRAME_LEN - 1);

  assign frame_first = (slot == '0);
  assign frame_last  = (slot == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (frame_last) begin
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

endmodule

// File: rtl/sap_snap_reg.sv
module sap_snap_reg
  import sap_pkg::*;
#(
  parameter int unsigned PAY_W = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PAY_W-1:0] pay_in,
  output logic [PAY_W-1:0] pay_next,
  output logic             held_next
);

  logic [PAY_W-1:0] pend_q;
  src_state_t       state_q;

  // A strobe in the boundary cycle itself goes straight to the next frame.
  assign pay_next  = load ? pay_in : pend_q;
  assign held_next = load || (state_q == SRC_HELD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      state_q <= SRC_EMPTY;
    end else if (load) begin
      pend_q  <= pay_in;
      state_q <= SRC_HELD;
    end
  end

endmodule

// File: rtl/sap_shifter.sv
module sap_shifter #(
  parameter int unsigned FRAME_LEN = 72,
  parameter int unsigned PAY_W     = 61
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_first,
  input  logic             frame_last,
  input  logic [PAY_W-1:0] pay_next,
  input  logic             held_next,
  output logic             ser_data,
  output logic             ser_mark
);

  localparam int unsigned PAD_W = FRAME_LEN - PAY_W;

  logic [FRAME_LEN-1:0] sh_q;
  logic [FRAME_LEN-1:0] frame_word;
  logic                 live_q;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_word = {pay_next, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame_word = pay_next;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      live_q   <= 1'b0;
      ser_data <= 1'b0;
      ser_mark <= 1'b0;
    end else begin
      ser_data <= sh_q[FRAME_LEN-1];
      ser_mark <= live_q && frame_first;
      if (frame_last) begin
        sh_q   <= frame_word;
        live_q <= held_next;
      end else begin
        sh_q   <= {sh_q[FRAME_LEN-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/sec_alarm_tx.sv
module sec_alarm_tx
  import sap_pkg::*;
#(
  parameter int unsigned FRAME_LEN = SAP_FRAME_LEN,
  parameter int unsigned ALM_W     = SAP_ALM_W,
  parameter int unsigned ERR_W     = SAP_ERR_W,
  parameter int unsigned BYTE_W    = SAP_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap_load,
  input  logic              in_rdi,
  input  logic [ALM_W-1:0]  in_alarm,
  input  logic [ERR_W-1:0]  in_b1_err,
  input  logic [ERR_W-1:0]  in_b2_err,
  input  logic [BYTE_W-1:0] in_k1,
  input  logic [BYTE_W-1:0] in_k2,
  input  logic [BYTE_W-1:0] in_s1,
  output logic              ser_data,
  output logic              ser_mark
);

  localparam int unsigned PAY_W = 1 + ALM_W + 2 * ERR_W + 3 * BYTE_W;
  localparam int unsigned PAD_W = FRAME_LEN - PAY_W;
  localparam int unsigned CW    = $clog2(FRAME_LEN);

  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_next;
  logic             held_next;
  logic [CW-1:0]    slot;
  logic             frame_first;
  logic             frame_last;

  assign pay_in = {in_rdi, in_alarm, in_b1_err, in_b2_err, in_k1, in_k2, in_s1};

  sap_slot_ctr #(
    .FRAME_LEN(FRAME_LEN)
  ) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .slot       (slot),
    .frame_first(frame_first),
    .frame_last (frame_last)
  );

  sap_snap_reg #(
    .PAY_W(PAY_W)
  ) snap_i (
    .clk      (clk),
    .rst      (rst),
    .load     (snap_load),
    .pay_in   (pay_in),
    .pay_next (pay_next),
    .held_next(held_next)
  );

  sap_shifter #(
    .FRAME_LEN(FRAME_LEN),
    .PAY_W    (PAY_W)
  ) shf_i (
    .clk        (clk),
    .rst        (rst),
    .frame_first(frame_first),
    .frame_last (frame_last),
    .pay_next   (pay_next),
    .held_next  (held_next),
    .ser_data   (ser_data),
    .ser_mark   (ser_mark)
  );

endmodule

// File: rtl/sap_checker.sv
module sap_checker #(
  parameter int unsigned FRAME_LEN = 72,
  parameter int unsigned PAD_W     = 11
) (
  input logic clk,
  input logic rst,
  input logic snap_load,
  input logic ser_data,
  input logic ser_mark
);

  localparam int unsigned GW = $clog2(FRAME_LEN + 2);
  localparam logic [GW-1:0] GAP_MAX  = {GW{1'b1}};
  localparam logic [GW-1:0] FLEN     = GW'(FRAME_LEN);
  localparam logic [GW-1:0] PAD_FROM = GW'(FRAME_LEN - PAD_W);

  logic          seen_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      seen_q <= seen_q | snap_load;
      if (ser_mark) begin
        gap_q <= GW'(1);
      end else if (gap_q != '0 && gap_q != GAP_MAX) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1: quiet line until a snapshot exists
  p_quiet_before_load_r1: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (!ser_data && !ser_mark));

  // R2: marker spacing is one frame
  p_mark_period_r2: assert property (@(posedge clk) disable iff (rst)
    ser_mark |-> (gap_q == '0 || gap_q == FLEN));

  // R2: no frame passes without a marker
  p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (gap_q != '0) |-> (gap_q <= FLEN));

  // R2: marker lasts one cycle
  p_mark_single_r2: assert property (@(posedge clk) disable iff (rst)
    ser_mark |=> !ser_mark);

  // R5: padding slots are zero
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (gap_q >= PAD_FROM && gap_q < FLEN) |-> !ser_data);

endmodule

bind sec_alarm_tx sap_checker #(
  .FRAME_LEN(FRAME_LEN),
  .PAD_W    (PAD_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .snap_load(snap_load),
  .ser_data (ser_data),
  .ser_mark (ser_mark)
);

// File: tb/sec_alarm_tx_tb_top.sv
module sec_alarm_tx_tb_top;

  localparam int FL = 72;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snap_load = 1'b0;
  logic        in_rdi = 1'b0;
  logic [3:0]  in_alarm = '0;
  logic [15:0] in_b1_err = '0;
  logic [15:0] in_b2_err = '0;
  logic [7:0]  in_k1 = '0;
  logic [7:0]  in_k2 = '0;
  logic [7:0]  in_s1 = '0;
  logic        ser_data;
  logic        ser_mark;

  int n_chk = 0;
  int n_bad = 0;
  int edge_n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) edge_n <= 0;
    else     edge_n <= edge_n + 1;
  end

  sec_alarm_tx dut_i (
    .clk(clk), .rst(rst), .snap_load(snap_load), .in_rdi(in_rdi),
    .in_alarm(in_alarm), .in_b1_err(in_b1_err), .in_b2_err(in_b2_err),
    .in_k1(in_k1), .in_k2(in_k2), .in_s1(in_s1),
    .ser_data(ser_data), .ser_mark(ser_mark)
  );

  function automatic logic [60:0] mk(input logic r, input logic [3:0] a,
      input logic [15:0] b1, input logic [15:0] b2,
      input logic [7:0] k1, input logic [7:0] k2, input logic [7:0] s1);
    return {r, a, b1, b2, k1, k2, s1};
  endfunction

  function automatic int cur_slot();
    return (edge_n - 1) % FL;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [60:0] p);
    {in_rdi, in_alarm, in_b1_err, in_b2_err, in_k1, in_k2, in_s1} = p;
    snap_load = 1'b1;
  endtask

  // Checks one whole frame. sa/sb: frame slot (1..71) at which a strobe is sampled.
  task automatic check_frame(input logic [60:0] exp, input int sa, input logic [60:0] pa,
                             input int sb, input logic [60:0] pb, input string tag);
    logic [FL-1:0] got;
    logic [FL-1:0] mks;
    do @(negedge clk); while (cur_slot() != 0);
    for (int s = 0; s < FL; s++) begin
      got[FL-1-s] = ser_data;
      mks[s] = ser_mark;
      snap_load = 1'b0;
      if (sa == s + 1) put(pa);
      if (sb == s + 1) put(pb);
      if (s < FL - 1) @(negedge clk);
    end
    chk(mks[0] && got[FL-1] == exp[60], {tag, " R3 marker/RDI slot"},
        {62'd0, mks[0], got[FL-1]}, {62'd0, 1'b1, exp[60]});
    chk(mks[FL-1:1] == '0, {tag, " R2 marker elsewhere"}, 64'(mks[FL-1:1]), 64'd0);
    chk(got[70:11] == exp[59:0], {tag, " R4 field order"}, 64'(got[70:11]), 64'(exp[59:0]));
    chk(got[10:0] == '0, {tag, " R5 padding"}, 64'(got[10:0]), 64'd0);
  endtask

  localparam logic [60:0] SA = 61'h0;

  logic [60:0] pA, pB, pC, pD, pE, pF;

  task automatic t_reset();
    bit bad_d = 0;
    bit bad_m = 0;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(!ser_data && !ser_mark, "R1 outputs in reset", {62'd0, ser_data, ser_mark}, 64'd0);
    rst = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ser_data) bad_d = 1;
      if (ser_mark) bad_m = 1;
    end
    chk(!bad_d, "R1 data idle after reset", 64'(bad_d), 64'd0);
    chk(!bad_m, "R1 marker idle after reset", 64'(bad_m), 64'd0);
  endtask

  task automatic t_first_load();
    bit early = 0;
    while (edge_n != 130) @(negedge clk);
    put(pA);
    @(negedge clk);
    snap_load = 1'b0;
    while (edge_n - 1 != 143) begin
      if (ser_mark || ser_data) early = 1;
      @(negedge clk);
    end
    if (ser_mark || ser_data) early = 1;
    chk(!early, "R9 no output before first boundary", 64'(early), 64'd0);
    check_frame(pA, 0, SA, 0, SA, "first frame R9");
  endtask

  task automatic t_repeat();
    check_frame(pA, 0, SA, 0, SA, "repeat R7 #1");
    check_frame(pA, 0, SA, 0, SA, "repeat R7 #2");
  endtask

  task automatic t_midframe();
    check_frame(pA, 30, pB, 0, SA, "mid-frame load R6 current");
    check_frame(pB, 0, SA, 0, SA, "mid-frame load R6 next");
  endtask

  task automatic t_last_wins();
    check_frame(pB, 10, pC, 50, pD, "two loads R8 current");
    check_frame(pD, 0, SA, 0, SA, "two loads R8 next");
  endtask

  task automatic t_slot71();
    check_frame(pD, 71, pE, 0, SA, "slot71 load R6 current");
    check_frame(pE, 1, pB, 0, SA, "slot71 load R6 next");
    check_frame(pB, 0, SA, 0, SA, "slot1 load R6 next");
  endtask

  task automatic t_slot0();
    while (cur_slot() != FL - 1) @(negedge clk);
    put(pF);
    check_frame(pB, 0, SA, 0, SA, "slot0 load R6 current");
    check_frame(pF, 0, SA, 0, SA, "slot0 load R6 next");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    pA = mk(1'b1, 4'b1010, 16'h1234, 16'hBEEF, 8'h5A, 8'hC3, 8'h0F);
    pB = mk(1'b0, 4'b0101, 16'h0001, 16'h8000, 8'h81, 8'h7E, 8'hF0);
    pC = mk(1'b1, 4'b1111, 16'hAAAA, 16'h5555, 8'h00, 8'hFF, 8'h33);
    pD = {61{1'b1}};
    pE = mk(1'b0, 4'b0001, 16'hFFFE, 16'h0000, 8'h12, 8'h34, 8'h56);
    pF = mk(1'b1, 4'b1000, 16'h00FF, 16'hFF00, 8'hA5, 8'h5A, 8'hCC);
    t_reset();
    t_first_load();
    t_repeat();
    t_midframe();
    t_last_wins();
    t_slot71();
    t_slot0();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

endmodule